// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block watches each local-bus transaction and makes sure none of them stalls forever. When a transaction starts, a down-counter is loaded with a programmable limit and decremented once per bus cycle. Every acknowledged data beat restores the full limit. When the data tenure finishes, the monitor goes idle, or it re-arms at once if another transaction is already waiting. If the count runs out, the block raises a one-cycle expiry pulse. The bus controller uses that pulse to abort the access and to take an exception. The same pulse sets a sticky error flag, unless reporting is masked.

The limit comes from an 8-bit field counted in units of eight bus cycles. A field of zero, which is also the reset value, selects the longest window of 2048 cycles. Nonzero values below five are not allowed and are raised to five, which gives 40 cycles. Masking the report only stops the flag from being set. The counter and the expiry pulse work the same way with or without the mask.

The control is a three-state machine. **ST_IDLE** moves to **ST_ARMED** on a transaction start (transition *arm*). **ST_ARMED** has four ways out:
- It returns to **ST_IDLE** when the tenure ends with nothing pending (transition *retire*).
- It stays in **ST_ARMED** and reloads on a beat acknowledge (transition *refresh*).
- It stays in **ST_ARMED** and reloads when the tenure ends with a transaction pending (transition *chain*).
- It moves to **ST_EXPIRE** when the final count cycle passes without any event (transition *expire*).

**ST_EXPIRE** always returns to **ST_IDLE** on the next cycle (transition *recover*).

Top module: `xact_timeout_mon`

## Requirements
- R1: After reset `tmo_expire`, `monitor_active` and `err_sticky` are all 0, and the machine is in ST_IDLE.
- R2: Suppose `xact_start` is sampled at clock edge E0 and no later event arrives. Then `tmo_expire` is high for exactly one cycle, the cycle after edge E0+L, where L is the decoded limit. `monitor_active` is high from E0 until edge E0+L.
- R3: A `tmo_field` value N of 5 or more gives L = 8*N cycles. A value of 0 gives L = 2048 cycles.
- R4: A `tmo_field` value from 1 to 4 gives L = 40 cycles.
- R5: A `beat_ack` sampled at edge A while armed reloads the full limit, so expiry moves to edge A+L. This also holds when A is the final edge of the current window.
- R6: A `tenure_done` sampled while armed with `xact_pending` low ends monitoring: `monitor_active` goes low and no expiry follows. `tenure_done` takes precedence over both `beat_ack` and expiry on the same edge.
- R7: A `tenure_done` sampled at edge D while armed with `xact_pending` high reloads the limit, and monitoring continues without going idle, so expiry moves to edge D+L.
- R8: In the cycle after the expiry pulse, `monitor_active` and `tmo_expire` are both 0 (ST_EXPIRE always returns to ST_IDLE).
- R9: An expiry pulse sampled with `report_dis` low sets `err_sticky` at the next edge. With `report_dis` high the flag is left unchanged, but the pulse still occurs with the same timing.
- R10: `status_clr` high at an edge clears `err_sticky`. If an expiry pulse that would set the flag is sampled on the same edge, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_start | input | 1 | A transaction begins (arms the monitor) |
| beat_ack | input | 1 | A data beat was acknowledged |
| tenure_done | input | 1 | The data tenure of the current transaction has completed |
| xact_pending | input | 1 | Another transaction is queued behind the current one |
| tmo_field | input | 8 | Timeout limit in units of 8 bus cycles, 0 = 2048 cycles |
| report_dis | input | 1 | Masks setting of the sticky error flag |
| status_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| tmo_expire | output | 1 | One-cycle expiry pulse (aborts access, raises exception) |
| monitor_active | output | 1 | Countdown is running |
| err_sticky | output | 1 | Sticky timeout error flag |

## Verification
The assertions assume that the bus controller raises `xact_start` only while the monitor is idle and not expiring. They also assume that `beat_ack` and `tenure_done` arrive only while a countdown is running, and that `tmo_field` stays unchanged for the duration of a transaction. The stimulus meets all of these conditions. Each case starts from idle with a single start pulse. Acknowledge and completion edges are placed no later than the window they fall in. The field is changed only between cases, while the monitor is idle.

// File: rtl/tmo_mon_pkg.sv
package tmo_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_EXPIRE = 2'd2
    } mon_state_e;

endpackage

// File: rtl/tmo_limit_decode.sv
module tmo_limit_decode #(
    parameter int FIELD_W    = 8,
    parameter int UNIT_SHIFT = 3,
    parameter int MIN_FIELD  = 5,
    parameter int CNT_W      = FIELD_W + UNIT_SHIFT + 1
) (
    input  logic [FIELD_W-1:0] fld,
    output logic [CNT_W-1:0]   limit
);
    localparam logic [FIELD_W-1:0] MIN_F   = FIELD_W'(MIN_FIELD);
    localparam logic [CNT_W-1:0]   MIN_LIM = CNT_W'(MIN_FIELD) << UNIT_SHIFT;
    localparam logic [CNT_W-1:0]   MAX_LIM = CNT_W'(1) << (FIELD_W + UNIT_SHIFT);

    logic [CNT_W-1:0] fld_ext;

    always_comb begin
        fld_ext = {{(CNT_W-FIELD_W){1'b0}}, fld};
        if (fld == '0)
            limit = MAX_LIM;          // zero encodes the longest window
        else if (fld < MIN_F)
            limit = MIN_LIM;          // illegal small values are clamped
        else
            limit = fld_ext << UNIT_SHIFT;
    end

endmodule

// File: rtl/tmo_down_counter.sv
module tmo_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == CNT_W'(1));

    // The controller never decrements from the final count.
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q > CNT_W'(1)));

endmodule

// File: rtl/tmo_err_flag.sv
module tmo_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic mask,
    input  logic clr,
    output logic flag
);
    logic set_ev;

    assign set_ev = expire && !mask;

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_ev)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire) && !$past(mask));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !flag);

endmodule

// File: rtl/xact_timeout_mon.sv
module xact_timeout_mon
    import tmo_mon_pkg::*;
#(
    parameter int FIELD_W    = 8,
    parameter int UNIT_SHIFT = 3,
    parameter int MIN_FIELD  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xact_start,
    input  logic               beat_ack,
    input  logic               tenure_done,
    input  logic               xact_pending,
    input  logic [FIELD_W-1:0] tmo_field,
    input  logic               report_dis,
    input  logic               status_clr,
    output logic               tmo_expire,
    output logic               monitor_active,
    output logic               err_sticky
);
    localparam int               CNT_W   = FIELD_W + UNIT_SHIFT + 1;
    localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(MIN_FIELD) << UNIT_SHIFT;
    localparam logic [CNT_W-1:0] MAX_LIM = CNT_W'(1) << (FIELD_W + UNIT_SHIFT);

    mon_state_e       state_q, state_d;
    logic [CNT_W-1:0] load_lim;
    logic             cnt_load, cnt_dec, cnt_last;

    tmo_limit_decode #(
        .FIELD_W(FIELD_W), .UNIT_SHIFT(UNIT_SHIFT),
        .MIN_FIELD(MIN_FIELD), .CNT_W(CNT_W)
    ) u_dec (
        .fld   (tmo_field),
        .limit (load_lim)
    );

    assert_limit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lim >= MIN_LIM) && (load_lim <= MAX_LIM) &&
        (load_lim[UNIT_SHIFT-1:0] == '0));

    tmo_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_lim),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (xact_start) begin           // arm
                    state_d  = ST_ARMED;
                    cnt_load = 1'b1;
                end
            end
            ST_ARMED: begin
                if (tenure_done) begin
                    if (xact_pending)
                        cnt_load = 1'b1;        // chain
                    else
                        state_d = ST_IDLE;      // retire
                end else if (beat_ack) begin
                    cnt_load = 1'b1;            // refresh
                end else if (cnt_last) begin
                    state_d = ST_EXPIRE;        // expire
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_EXPIRE: state_d = ST_IDLE;       // recover
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tmo_expire     = (state_q == ST_EXPIRE);
        monitor_active = (state_q == ST_ARMED);
    end

    tmo_err_flag u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (tmo_expire),
        .mask   (report_dis),
        .clr    (status_clr),
        .flag   (err_sticky)
    );

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> !tmo_expire);

    assert_pulse_from_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_expire) |-> $past(monitor_active));

    assert_idle_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> !monitor_active);

    assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor_active && tenure_done && !xact_pending) |=> (!monitor_active && !tmo_expire));

    assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor_active && tenure_done && xact_pending) |=> monitor_active);

    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_expire && !report_dis) |=> err_sticky);

endmodule

// File: tb/xact_timeout_mon_test.sv
`timescale 1ns/1ps
module xact_timeout_mon_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xact_start = 1'b0, beat_ack = 1'b0, tenure_done = 1'b0;
    logic       xact_pending = 1'b0, report_dis = 1'b0, status_clr = 1'b0;
    logic [7:0] tmo_field = 8'd0;
    logic       tmo_expire, monitor_active, err_sticky;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    xact_timeout_mon uut (
        .clk(clk), .rst_n(rst_n), .xact_start(xact_start), .beat_ack(beat_ack),
        .tenure_done(tenure_done), .xact_pending(xact_pending), .tmo_field(tmo_field),
        .report_dis(report_dis), .status_clr(status_clr), .tmo_expire(tmo_expire),
        .monitor_active(monitor_active), .err_sticky(err_sticky)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim_of(input int f);
        if (f == 0) return 2048;
        if (f < 5)  return 40;
        return f * 8;
    endfunction

    // One transaction from idle. Edge numbers count from the start edge (0).
    // a1/a2: beat acknowledge edges, dn: tenure-done edge, clr_at: clear edge (0 = none).
    task automatic run_case(input int fld, input int a1, input int a2, input int dn,
                            input bit pend, input bit rdis, input int clr_at,
                            input string tag);
        int L, dl, fire, stop_k, first_hi, hi_cnt, act_bad;
        bit err_seen;
        L = lim_of(fld);
        dl = L;
        if (a1 != 0 && a1 <= dl && (dn == 0 || a1 < dn)) dl = a1 + L;
        if (a2 != 0 && a2 <= dl && (dn == 0 || a2 < dn)) dl = a2 + L;
        fire = dl;
        if (dn != 0 && dn <= dl) fire = pend ? dn + L : 0;
        stop_k = (fire != 0) ? fire + 1 : dn + 1;
        first_hi = 0; hi_cnt = 0; act_bad = 0; err_seen = 1'b0;
        tmo_field = 8'(fld);
        report_dis = rdis;
        xact_start = 1'b1;
        @(posedge clk); @(negedge clk);
        xact_start = 1'b0;
        for (int k = 1; k <= stop_k; k++) begin
            beat_ack     = (k == a1) || (k == a2);
            tenure_done  = (k == dn);
            xact_pending = pend && (k == dn);
            status_clr   = (k == clr_at);
            @(posedge clk); @(negedge clk);
            if (tmo_expire) begin
                hi_cnt++;
                if (first_hi == 0) first_hi = k;
            end
            if (monitor_active !== ((fire != 0) ? (k < fire) : (k < dn))) act_bad++;
            if (k == stop_k) err_seen = err_sticky;
        end
        beat_ack = 1'b0; tenure_done = 1'b0; xact_pending = 1'b0; status_clr = 1'b0;
        check(first_hi == fire && hi_cnt == ((fire != 0) ? 1 : 0),
              {tag, " expiry edge"}, first_hi, fire);
        check(act_bad == 0, {tag, " active window R8"}, act_bad, 0);
        check(err_seen == ((fire != 0) && !rdis), {tag, " error flag R9"},
              int'(err_seen), int'((fire != 0) && !rdis));
        // clear the flag through the normal strobe (R10)
        status_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        status_clr = 1'b0;
        check(err_sticky == 1'b0 && monitor_active == 1'b0, {tag, " cleared R10"},
              int'(err_sticky), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tmo_expire == 0 && monitor_active == 0 && err_sticky == 0,
              "R1 outputs in reset", {tmo_expire, monitor_active, err_sticky}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tmo_expire == 0 && monitor_active == 0 && err_sticky == 0,
              "R1 outputs after reset", {tmo_expire, monitor_active, err_sticky}, 0);

        // R2/R3/R4: sweep of the field, alternating the report mask (R9)
        for (int f = 0; f <= 40; f++)
            run_case(f, 0, 0, 0, 1'b0, 1'(f % 2), 0,
                     (f == 0) ? "R3 zero field" : (f < 5) ? "R4 clamp" : "R2 R3 sweep");
        run_case(255, 0, 0, 0, 1'b0, 1'b0, 0, "R3 top field");

        // R5: beat reloads
        run_case(5, 10, 0, 0, 1'b0, 1'b0, 0, "R5 early beat");
        run_case(5, 40, 0, 0, 1'b0, 1'b0, 0, "R5 beat on last edge");
        run_case(5, 20, 55, 0, 1'b0, 1'b0, 0, "R5 two beats");
        run_case(7, 39, 95, 0, 1'b0, 1'b1, 0, "R5 beats masked R9");

        // R6: retire, and precedence
        run_case(5, 0, 0, 30, 1'b0, 1'b0, 0, "R6 retire");
        run_case(5, 0, 0, 40, 1'b0, 1'b0, 0, "R6 done beats expiry");
        run_case(5, 25, 0, 25, 1'b0, 1'b0, 0, "R6 done beats ack");
        run_case(6, 12, 0, 50, 1'b0, 1'b0, 0, "R6 retire after beat");

        // R7: chained reload
        run_case(5, 0, 0, 30, 1'b1, 1'b0, 0, "R7 chain");
        run_case(5, 0, 0, 40, 1'b1, 1'b0, 0, "R7 chain on last edge");
        run_case(9, 30, 0, 60, 1'b1, 1'b0, 0, "R7 chain after beat");

        // R10: a clear on the same edge as the setting pulse loses
        run_case(5, 0, 0, 0, 1'b0, 1'b0, 41, "R10 set beats clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule